// File: doc/BRIEF.md
# Ultra DMA burst strobe timer

This block paces the host side of an Ultra DMA data burst. Two drives (by default) each hold their own strobe cycle setting and their own read-termination delay. Both are counted in base-clock periods and can be rewritten at any time through a small configuration write port. When a burst starts, the block latches the drive select and the direction. On a write burst it drives the strobe. The strobe changes level once every programmed cycle count while the handshake allows it, and a 16-bit word goes out on each edge, rising or falling. A one-cycle data-advance pulse announces each edge so the word source can step ahead.

On a read burst the device owns the strobe, so the host strobe output stays at its idle high level. When the host wants a read burst to end, it raises a pause request. The block then waits the drive's programmed number of base clocks of device-ready low before it asserts STOP. On a write burst a pause request asserts STOP on the next clock. STOP stays up until burst start is withdrawn. The block then returns to idle with the strobe high.

Top module: `udst_top`

## Requirements
- R1: While reset is asserted and right after it, host_strobe is 1 and stop, busy and data_adv are 0.
- R2: busy rises in the cycle after burst_start is seen high in idle. It falls in the cycle after burst_start is seen low in any active state.
- R3: In a write burst (burst_write=1 at start), host_strobe changes level once every C qualified cycles. C is the cycle setting of the drive latched at burst start.
- R4: data_adv is high in exactly the cycles whose following clock edge changes host_strobe during a burst. It is never high while idle.
- R5: A cycle setting of 0 behaves exactly like a setting of 1, so the strobe changes every qualified cycle.
- R6: A write cycle counts as qualified only when data_ok and dev_ready are both 1. Otherwise the strobe and its cycle count hold.
- R7: In a read burst (burst_write=0 at start), host_strobe stays 1 whatever data_ok and dev_ready do.
- R8: In a read burst, once a pause is pending (pause_req seen), STOP rises P clock cycles after the first cycle with the pause pending and dev_ready low. P is the drive's pause setting, with 0 treated as 1. A cycle with dev_ready high restarts that count.
- R9: In a write burst, pause_req asserts stop on the next cycle. While stop is high the strobe does not change and data_adv stays 0.
- R10: stop stays high while burst_start stays high. Once burst_start is low, the next cycle shows stop 0, busy 0 and host_strobe 1.
- R11: A configuration write (cfg_we) changes only the drive named by cfg_sel. It takes effect from the next cycle, including during a burst on that drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write the timing settings of drive cfg_sel |
| cfg_sel | input | SEL_W | Drive addressed by a configuration write |
| cfg_cycle | input | CNT_W | Strobe cycle setting in base clocks |
| cfg_pause | input | CNT_W | Read-termination delay in base clocks |
| drive_sel | input | SEL_W | Drive used by the burst, latched at start |
| burst_start | input | 1 | Burst request; held high for the whole burst |
| burst_write | input | 1 | 1 = write burst, 0 = read burst, latched at start |
| data_ok | input | 1 | Host data available for the next write word |
| dev_ready | input | 1 | Device ready signal |
| pause_req | input | 1 | Host request to end the burst |
| host_strobe | output | 1 | Host-driven data strobe, idle high |
| stop | output | 1 | Burst stop to the device |
| data_adv | output | 1 | Next write word requested; strobe changes at the next edge |
| busy | output | 1 | A burst is active |

## Verification
The hardest case to reach from the ports is the read-termination count restarting partway through. That needs a pause pending, dev_ready falling, then rising for one cycle, then falling again, all before STOP. The stimulus builds that exact sequence on a drive whose delay is longer than the gap. A second hard case is reprogramming one drive while a burst on the other drive runs. The bench writes the idle drive's setting in the middle of a write burst and checks that the running strobe period does not change.

// File: rtl/udst_pkg.sv
package udst_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_READ  = 2'd2,
      ST_HALT  = 2'd3
   } burst_state_t;

endpackage

// File: rtl/udst_timing_bank.sv
module udst_timing_bank #(
   parameter int NUM_DRIVES = 2,
   parameter int CNT_W      = 4,
   parameter int SEL_W      = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [CNT_W-1:0] wr_cycle,
   input  logic [CNT_W-1:0] wr_pause,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [CNT_W-1:0] cycle_eff,
   output logic [CNT_W-1:0] pause_eff
);

   localparam int ALL_W = NUM_DRIVES * CNT_W;

   logic [ALL_W-1:0] cycle_all;
   logic [ALL_W-1:0] pause_all;
   logic [CNT_W-1:0] cycle_raw;
   logic [CNT_W-1:0] pause_raw;

   for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
      logic [CNT_W-1:0] cycle_r;
      logic [CNT_W-1:0] pause_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cycle_r <= '0;
            pause_r <= '0;
         end else if (wr_en && (wr_sel == SEL_W'(d))) begin
            cycle_r <= wr_cycle;
            pause_r <= wr_pause;
         end
      end

      assign cycle_all[d*CNT_W +: CNT_W] = cycle_r;
      assign pause_all[d*CNT_W +: CNT_W] = pause_r;
   end

   always_comb begin
      cycle_raw = '0;
      pause_raw = '0;
      for (int d = 0; d < NUM_DRIVES; d++) begin
         if (rd_sel == SEL_W'(d)) begin
            cycle_raw = cycle_all[d*CNT_W +: CNT_W];
            pause_raw = pause_all[d*CNT_W +: CNT_W];
         end
      end
   end

   assign cycle_eff = (cycle_raw == '0) ? CNT_W'(1) : cycle_raw;
   assign pause_eff = (pause_raw == '0) ? CNT_W'(1) : pause_raw;

endmodule

// File: rtl/udst_strobe_gen.sv
module udst_strobe_gen #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_idle,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             tick,
   output logic             strobe
);

   logic [CNT_W-1:0] cnt_q;

   assign tick = run && (cnt_q >= (limit - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         strobe <= 1'b1;
      end else if (go_idle) begin
         cnt_q  <= '0;
         strobe <= 1'b1;
      end else if (run) begin
         if (tick) begin
            cnt_q  <= '0;
            strobe <= ~strobe;
         end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/udst_pause_timer.sv
module udst_pause_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             active,
   input  logic             pause_req,
   input  logic             dev_ready,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);

   logic             armed_q;
   logic             pending;
   logic [CNT_W-1:0] wait_q;

   assign pending = armed_q || pause_req;
   assign expire  = active && pending && !dev_ready &&
                    (wait_q >= (limit - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         wait_q  <= '0;
      end else if (clr) begin
         armed_q <= 1'b0;
         wait_q  <= '0;
      end else if (active && pending) begin
         armed_q <= 1'b1;
         if (dev_ready) begin
            wait_q <= '0;
         end else if (!expire) begin
            wait_q <= wait_q + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/udst_top.sv
module udst_top
   import udst_pkg::*;
#(
   parameter int NUM_DRIVES = 2,
   parameter int CNT_W      = 4,
   parameter int SEL_W      = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [CNT_W-1:0] cfg_cycle,
   input  logic [CNT_W-1:0] cfg_pause,
   input  logic [SEL_W-1:0] drive_sel,
   input  logic             burst_start,
   input  logic             burst_write,
   input  logic             data_ok,
   input  logic             dev_ready,
   input  logic             pause_req,
   output logic             host_strobe,
   output logic             stop,
   output logic             data_adv,
   output logic             busy
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("udst_top: CNT_W must be at least 2");
   end
   if (NUM_DRIVES < 1) begin : g_bad_drv
      $error("udst_top: NUM_DRIVES must be at least 1");
   end
   if ((1 << SEL_W) < NUM_DRIVES) begin : g_bad_sel
      $error("udst_top: SEL_W too narrow for NUM_DRIVES");
   end

   burst_state_t     state_q;
   burst_state_t     state_d;
   logic [SEL_W-1:0] drv_q;
   logic [CNT_W-1:0] cycle_eff;
   logic [CNT_W-1:0] pause_eff;
   logic             wr_run;
   logic             rd_active;
   logic             expire;
   logic             go_idle;

   udst_timing_bank #(
      .NUM_DRIVES (NUM_DRIVES),
      .CNT_W      (CNT_W),
      .SEL_W      (SEL_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_sel    (cfg_sel),
      .wr_cycle  (cfg_cycle),
      .wr_pause  (cfg_pause),
      .rd_sel    (drv_q),
      .cycle_eff (cycle_eff),
      .pause_eff (pause_eff)
   );

   assign wr_run    = (state_q == ST_WRITE) && burst_start && !pause_req &&
                      data_ok && dev_ready;
   assign rd_active = (state_q == ST_READ) && burst_start;
   assign go_idle   = (state_q == ST_IDLE) || !burst_start;

   udst_strobe_gen #(
      .CNT_W (CNT_W)
   ) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_idle (go_idle),
      .run     (wr_run),
      .limit   (cycle_eff),
      .tick    (data_adv),
      .strobe  (host_strobe)
   );

   udst_pause_timer #(
      .CNT_W (CNT_W)
   ) u_pause (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (state_q != ST_READ),
      .active    (rd_active),
      .pause_req (pause_req),
      .dev_ready (dev_ready),
      .limit     (pause_eff),
      .expire    (expire)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (burst_start) begin
               state_d = burst_write ? ST_WRITE : ST_READ;
            end
         end
         ST_WRITE: begin
            if (!burst_start)   state_d = ST_IDLE;
            else if (pause_req) state_d = ST_HALT;
         end
         ST_READ: begin
            if (!burst_start) state_d = ST_IDLE;
            else if (expire)  state_d = ST_HALT;
         end
         ST_HALT: begin
            if (!burst_start) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         drv_q   <= '0;
      end else begin
         state_q <= state_d;
         if ((state_q == ST_IDLE) && burst_start) begin
            drv_q <= drive_sel;
         end
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign stop = (state_q == ST_HALT);

endmodule

module udst_checker (
   input logic clk,
   input logic rst_n,
   input logic burst_start,
   input logic host_strobe,
   input logic stop,
   input logic data_adv,
   input logic busy
);

   AST_ADV_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      data_adv |=> (host_strobe != $past(host_strobe))); // R4
   AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && burst_start && !data_adv) |=> $stable(host_strobe)); // R4
   AST_IDLE_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !data_adv); // R4
   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> host_strobe); // R10
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && burst_start) |=> stop); // R10
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !burst_start) |=> (!busy && !stop)); // R2
   AST_STOP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      stop |-> busy); // R9
   AST_STOP_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      stop |-> !data_adv); // R9

endmodule

bind udst_top udst_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .burst_start (burst_start),
   .host_strobe (host_strobe),
   .stop        (stop),
   .data_adv    (data_adv),
   .busy        (busy)
);

// File: tb/sim_udst_top.sv
`timescale 1ns/1ps
module sim_udst_top;

   localparam int CNT_W = 4;
   localparam int SEL_W = 1;

   logic clk = 1'b0;
   logic rst_n;
   logic cfg_we;
   logic [SEL_W-1:0] cfg_sel;
   logic [CNT_W-1:0] cfg_cycle;
   logic [CNT_W-1:0] cfg_pause;
   logic [SEL_W-1:0] drive_sel;
   logic burst_start, burst_write, data_ok, dev_ready, pause_req;
   logic host_strobe, stop, data_adv, busy;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   int m_ct[2];
   int m_rp[2];
   int m_st;
   int m_cnt;
   int m_pc;
   int m_drv;
   bit m_arm;
   bit m_strobe;
   string tag = "R1";

   always #2 clk = ~clk;

   udst_top u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_cycle(cfg_cycle), .cfg_pause(cfg_pause), .drive_sel(drive_sel),
      .burst_start(burst_start), .burst_write(burst_write), .data_ok(data_ok),
      .dev_ready(dev_ready), .pause_req(pause_req), .host_strobe(host_strobe),
      .stop(stop), .data_adv(data_adv), .busy(busy)
   );

   task automatic chk(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int eff(int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic step();
      int  ct, rp;
      bit  run, adv, expire, pend;
      #1;
      ct     = eff(m_ct[m_drv]);
      rp     = eff(m_rp[m_drv]);
      pend   = m_arm || pause_req;
      run    = (m_st == 1) && burst_start && !pause_req && data_ok && dev_ready;
      adv    = run && (m_cnt >= ct - 1);
      expire = (m_st == 2) && burst_start && pend && !dev_ready && (m_pc >= rp - 1);
      chk("R2", busy, (m_st != 0), "busy");
      chk("R4", data_adv, adv, "data_adv");
      chk((m_st == 2) ? "R7" : tag, host_strobe, m_strobe, "host_strobe");
      chk(tag, stop, (m_st == 3), "stop");
      @(posedge clk);
      cycles++;
      case (m_st)
         0: if (burst_start) begin
               m_st  = burst_write ? 1 : 2;
               m_drv = drive_sel;
               m_cnt = 0; m_pc = 0; m_arm = 0;
            end
         1: if (!burst_start) begin m_st = 0; m_strobe = 1; m_cnt = 0; end
            else if (pause_req) m_st = 3;
            else if (run) begin
               if (adv) begin m_strobe = !m_strobe; m_cnt = 0; end
               else m_cnt++;
            end
         2: if (!burst_start) m_st = 0;
            else if (expire) m_st = 3;
            else if (pend) begin
               m_arm = 1;
               if (dev_ready) m_pc = 0; else m_pc++;
            end
         default: if (!burst_start) begin m_st = 0; m_strobe = 1; m_cnt = 0; end
      endcase
      if (cfg_we) begin
         m_ct[cfg_sel] = cfg_cycle;
         m_rp[cfg_sel] = cfg_pause;
      end
      @(negedge clk);
   endtask

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic cfg(int sel, int ct, int rp);
      cfg_we = 1; cfg_sel = SEL_W'(sel);
      cfg_cycle = CNT_W'(ct); cfg_pause = CNT_W'(rp);
      step();
      cfg_we = 0;
   endtask

   task automatic count_edges(int n, output int edges);
      bit prev;
      edges = 0;
      for (int i = 0; i < n; i++) begin
         prev = host_strobe;
         step();
         if (host_strobe != prev) edges++;
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #40000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int e;
      rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_cycle = 0; cfg_pause = 0;
      drive_sel = 0; burst_start = 0; burst_write = 0; data_ok = 0;
      dev_ready = 0; pause_req = 0;
      m_ct[0] = 0; m_ct[1] = 0; m_rp[0] = 0; m_rp[1] = 0;
      m_st = 0; m_cnt = 0; m_pc = 0; m_drv = 0; m_arm = 0; m_strobe = 1;
      repeat (3) @(negedge clk);
      chk("R1", host_strobe, 1, "reset strobe");
      chk("R1", stop, 0, "reset stop");
      chk("R1", busy, 0, "reset busy");
      chk("R1", data_adv, 0, "reset data_adv");
      rst_n = 1;
      cyc(2);

      cfg(0, 3, 2);
      cfg(1, 0, 4);

      // R3: write burst on drive 0, cycle setting 3
      tag = "R3";
      drive_sel = 0; burst_write = 1; data_ok = 1; dev_ready = 1; burst_start = 1;
      step();
      count_edges(12, e);
      chk("R3", e, 4, "edges in 12 cycles at setting 3");
      cyc(5);

      // R6: handshake stalls
      tag = "R6";
      data_ok = 0; cyc(4);
      data_ok = 1; dev_ready = 0; cyc(3);
      dev_ready = 1; cyc(5);

      // R9: pause on write
      tag = "R9";
      pause_req = 1; step();
      pause_req = 0; cyc(4);
      chk("R9", stop, 1, "stop after write pause");

      // R10: release
      tag = "R10";
      burst_start = 0; step();
      chk("R10", stop, 0, "stop released");
      chk("R10", host_strobe, 1, "strobe idle high");
      cyc(2);

      // R5: drive 1 has cycle setting 0
      tag = "R5";
      drive_sel = 1; burst_write = 1; burst_start = 1;
      step();
      count_edges(6, e);
      chk("R5", e, 6, "edges in 6 cycles at setting 0");
      burst_start = 0; cyc(2);

      // R11: reprogram drive 1 during a drive 0 burst
      tag = "R11";
      drive_sel = 0; burst_start = 1;
      step();
      cyc(2);
      cfg(1, 2, 4);
      count_edges(12, e);
      chk("R11", e, 4, "drive 0 period unchanged");
      burst_start = 0; cyc(2);

      // R8: read on drive 1, pause setting 4, with a restart
      tag = "R8";
      drive_sel = 1; burst_write = 0; dev_ready = 1; burst_start = 1;
      cyc(5);
      pause_req = 1; step();
      pause_req = 0; cyc(2);
      dev_ready = 0; cyc(2);
      dev_ready = 1; step();
      dev_ready = 0; cyc(3);
      chk("R8", stop, 0, "no stop before count restarts complete");
      cyc(2);
      chk("R8", stop, 1, "stop after pause delay");
      burst_start = 0; cyc(2);

      // R7: read on drive 0 with noisy handshake
      tag = "R7";
      drive_sel = 0; burst_start = 1;
      for (int i = 0; i < 8; i++) begin
         dev_ready = i[0]; data_ok = i[1];
         step();
      end
      chk("R7", host_strobe, 1, "read strobe high");
      burst_start = 0; cyc(2);

      // R2: aborted write
      tag = "R2";
      burst_write = 1; dev_ready = 1; data_ok = 1; burst_start = 1;
      cyc(5);
      burst_start = 0; step();
      chk("R2", busy, 0, "busy dropped after abort");
      cyc(2);

      finish_run();
   end

endmodule